// File: doc/BRIEF.md
# Memory-fed double-buffered PWM bank

This block drives a bank of pulse-width outputs (twelve by default) that all share one period counter. The period length in clock cycles is a run-time value. Each output is high at the start of every period and falls once the counter reaches that channel's compare value. At a 16 MHz clock, a top value of 16 gives a 1 MHz PWM rate.

The compare values come from memory through a word-wide read port. Each 32-bit word holds the compare values for two neighbouring channels, so a full set of twelve channels takes six reads. Reads go through a simple request/acknowledge handshake. Words are written into a shadow set. The whole shadow set is copied into the active compare registers in one step, and only at a period boundary.

Fetching of the next set starts in the cycle after each copy, so a full period is available for memory to deliver it. If memory is slow and the set is not complete at the boundary, every channel simply repeats its previous duty. Outputs therefore never show a partial or mid-period update.

Top module: `pwm_dma_bank`

## Requirements
- R1: While reset is active and in the first cycle after reset, every PWM output is low, the read request is low and the period-start flag is low.
- R2: While running, the period is `top_count` cycles long, with a value of 0 treated as 1. `period_start` is high exactly in the cycle where the counter is 0. The counter starts at 0 in the first cycle after `run` is seen high.
- R3: While running, output i is high when the count is below its active 16-bit compare value and low otherwise. A value of 0 keeps it low for the whole period, and a value at or above `top_count` keeps it high for the whole period.
- R4: Channel 2k takes bits 15:0 of the k-th word of a set, and channel 2k+1 takes bits 31:16.
- R5: The words of a set are read at word addresses `base_addr`, `base_addr`+1, … in increasing order, wrapping modulo 2^AW. A request holds its address steady until it is acknowledged. A word is accepted in the cycle where `rd_req` and `rd_ack` are both high, with `rd_data` valid in that same cycle.
- R6: A fetch of a new set begins, with `rd_req` high, in the cycle after the active values are loaded, and also in the cycle after running starts when no complete set is waiting. No other fetch is started.
- R7: Active compare values change only as a period starts, so no output rises in any cycle other than the first cycle of a period.
- R8: If the set is incomplete at a boundary, all channels keep their previous compare values for the next period. The set is applied at the first boundary after it completes.
- R9: A set whose last word is accepted in the final cycle of a period is applied at the boundary that ends that period.
- R10: While `run` is low, the counter is held, all outputs are low and no new fetch begins. A read already in progress completes, and the active values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Enables the period counter and outputs |
| top_count | input | CW | Period length in cycles |
| base_addr | input | AW | Word address of the first word of a set; held while fetching |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Word address of the request |
| rd_ack | input | 1 | Read accepted, data valid this cycle |
| rd_data | input | 2*CW | Read data: two compare values |
| period_start | output | 1 | High in the first cycle of each period |
| pwm | output | NCH | PWM outputs |

## Verification
The risky overlap is the last read of a set being acknowledged in the same cycle as the period boundary, where the data must be copied into the active registers straight from the read bus. The bench provokes this by acknowledging five words at once and holding the sixth until the counter shows its final value. The outputs of the next period are then compared against a cycle model that applies the new set. A second overlap comes from starving the read port so that a boundary passes with a half-filled shadow set: the outputs must repeat the old duty, and a rise in the middle of a period is reported.

// File: rtl/pwm_dma_pkg.sv
// Package pwm_dma_pkg
// Shared types for the memory-fed PWM bank.
// Assumes: nothing beyond standard SystemVerilog.
package pwm_dma_pkg;

    // Read engine state: waiting for a start condition, or walking the words of a set.
    typedef enum logic {
        FETCH_IDLE = 1'b0,
        FETCH_BUSY = 1'b1
    } fetch_state_e;

    // Number of compare values packed into one read word.
    localparam int VALS_PER_WORD = 2;

endpackage

// File: rtl/pwm_dma_timebase.sv
// Module pwm_dma_timebase
// Shared period counter. It counts 0 .. top-1 while the registered run flag is
// high and holds at 0 otherwise. It flags the last cycle (wrap) and the first
// cycle (first) of every period.
// Assumes: a top_count of 0 acts as 1; top_count may change at any time, and
// the counter then wraps as soon as it reaches or passes the new last value.
module pwm_dma_timebase #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] top_count,
    output logic          run_q,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          first
);

    logic [CW-1:0] last_val;

    // Last count value of a period; a zero top is treated as a one-cycle period.
    always_comb last_val = (top_count == '0) ? '0 : top_count - 1'b1;

    assign wrap  = run_q && (cnt >= last_val);
    assign first = run_q && (cnt == '0);

    // Register run and advance or clear the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt   <= '0;
        end else begin
            run_q <= run;
            if (!run_q || wrap) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: a period that reaches its last cycle restarts at zero.
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_dma_fetch.sv
// Module pwm_dma_fetch
// Read engine and shadow set. It walks NW word addresses from base_addr,
// storing each accepted word in the shadow set. A complete set raises a valid
// flag. At a boundary the set is handed over (load) if it is valid or if its
// last word arrives in that very cycle. The handover clears the flag, and a
// new fetch starts once the engine is idle with no valid set.
// Assumes: base_addr is stable while a fetch is in progress; rd_data is valid
// in the cycle where rd_req and rd_ack are both high.
module pwm_dma_fetch
    import pwm_dma_pkg::*;
#(
    parameter int NW = 6,
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q,
    input  logic             boundary,
    input  logic [AW-1:0]    base_addr,
    input  logic             rd_ack,
    input  logic [DW-1:0]    rd_data,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic             load,
    output logic [NW*DW-1:0] set_flat
);

    localparam int IW = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

    fetch_state_e  state;
    logic [IW-1:0] idx;
    logic          set_valid;
    logic [DW-1:0] shadow      [NW];
    logic [DW-1:0] shadow_next [NW];
    logic          take;
    logic          last_take;

    assign rd_req    = (state == FETCH_BUSY);
    assign rd_addr   = base_addr + AW'(idx);
    assign take      = rd_req && rd_ack;
    assign last_take = take && (idx == LAST_IDX);
    assign load      = boundary && (set_valid || last_take);

    // Shadow set as it stands after this cycle's read, so a last-cycle word can pass straight through.
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            shadow_next[w] = shadow[w];
        end
        if (take) begin
            shadow_next[idx] = rd_data;
        end
    end

    // Flatten the shadow set for the channel bank.
    for (genvar w = 0; w < NW; w++) begin : g_flat
        assign set_flat[w*DW +: DW] = shadow_next[w];
    end

    // Store accepted words into the shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NW; w++) begin
                shadow[w] <= '0;
            end
        end else if (take) begin
            shadow[idx] <= rd_data;
        end
    end

    // Sequence the word reads of one set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FETCH_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                FETCH_IDLE: begin
                    if (!set_valid && run_q) begin
                        state <= FETCH_BUSY;
                        idx   <= '0;
                    end
                end
                FETCH_BUSY: begin
                    if (take) begin
                        if (idx == LAST_IDX) begin
                            state <= FETCH_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= FETCH_IDLE;
            endcase
        end
    end

    // Track whether a complete set is waiting for a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_valid <= 1'b0;
        end else if (load) begin
            set_valid <= 1'b0;
        end else if (last_take) begin
            set_valid <= 1'b1;
        end
    end

    // R5: an unacknowledged request stays up with the same address.
    a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R6: a handed-over set is followed by a new fetch in the next cycle.
    a_r6_prefetch_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(set_valid) && run_q) |=> rd_req);

endmodule

// File: rtl/pwm_dma_chan.sv
// Module pwm_dma_chan
// Active compare registers and comparators. On load, all channels take their
// new value together from the flattened set. Channel i reads bits
// [i*CW +: CW], which puts channel 2k in the low half of word k. Each output
// is high while the shared count is below its compare value.
// Assumes: load is raised only in the last cycle of a period.
module pwm_dma_chan #(
    parameter int NCH = 12,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_q,
    input  logic [CW-1:0]     cnt,
    input  logic              load,
    input  logic [NCH*CW-1:0] set_flat,
    output logic [NCH-1:0]    pwm
);

    logic [NCH*CW-1:0] act_flat;

    // Copy the whole shadow set into the active registers at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_flat <= '0;
        end else if (load) begin
            act_flat <= set_flat;
        end
    end

    // One comparator per channel against the shared count.
    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        assign pwm[i] = run_q && (cnt < act_flat[i*CW +: CW]);
    end

    // R7: active values only ever change when the counter has just restarted.
    a_r7_update_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_flat) |-> (cnt == '0));

endmodule

// File: rtl/pwm_dma_bank.sv
// Module pwm_dma_bank
// Top level of the memory-fed double-buffered PWM bank: period counter,
// read engine with shadow set, and channel comparators.
// Assumes: NCH is even (two compare values per read word); base_addr is held
// while a fetch is in progress.
module pwm_dma_bank
    import pwm_dma_pkg::*;
#(
    parameter int NCH = 12,
    parameter int CW  = 16,
    parameter int AW  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic [CW-1:0]              top_count,
    input  logic [AW-1:0]              base_addr,
    output logic                       rd_req,
    output logic [AW-1:0]              rd_addr,
    input  logic                       rd_ack,
    input  logic [VALS_PER_WORD*CW-1:0] rd_data,
    output logic                       period_start,
    output logic [NCH-1:0]             pwm
);

    localparam int DW = VALS_PER_WORD * CW;
    localparam int NW = NCH / VALS_PER_WORD;

    logic          run_q;
    logic [CW-1:0] cnt;
    logic          wrap;
    logic          load;
    logic [NW*DW-1:0] set_flat;

    pwm_dma_timebase #(.CW(CW)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .top_count (top_count),
        .run_q     (run_q),
        .cnt       (cnt),
        .wrap      (wrap),
        .first     (period_start)
    );

    pwm_dma_fetch #(.NW(NW), .DW(DW), .AW(AW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_q     (run_q),
        .boundary  (wrap),
        .base_addr (base_addr),
        .rd_ack    (rd_ack),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .load      (load),
        .set_flat  (set_flat)
    );

    pwm_dma_chan #(.NCH(NCH), .CW(CW)) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_q    (run_q),
        .cnt      (cnt),
        .load     (load),
        .set_flat (set_flat),
        .pwm      (pwm)
    );

    // R10: a low run input forces every output low from the next cycle.
    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm == '0));

endmodule

// File: tb/test_pwm_dma_bank.sv
// Bench for pwm_dma_bank: a cycle model built from the requirements, random
// read latency and data from a fixed seed, plus directed corner phases.
module test_pwm_dma_bank;

    localparam int NCH = 12;
    localparam int CW  = 16;
    localparam int AW  = 16;
    localparam int NW  = NCH / 2;
    localparam int DW  = 2 * CW;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           run;
    logic [CW-1:0]  top_count;
    logic [AW-1:0]  base_addr;
    logic           rd_req;
    logic [AW-1:0]  rd_addr;
    logic           rd_ack;
    logic [DW-1:0]  rd_data;
    logic           period_start;
    logic [NCH-1:0] pwm;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    int    mode = 0;
    string cur_tag = "R3";

    // Reference model state (values after the latest clock edge).
    int          m_cnt = 0;
    bit          m_run = 1'b0;
    bit          m_busy = 1'b0;
    int          m_idx = 0;
    bit          m_valid = 1'b0;
    logic [DW-1:0] m_shd [NW];
    logic [CW-1:0] m_act [NCH];
    logic [NCH-1:0] prev_pwm = '0;

    always #5 clk = ~clk;

    pwm_dma_bank #(.NCH(NCH), .CW(CW), .AW(AW)) i_pwm_dma_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .top_count    (top_count),
        .base_addr    (base_addr),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_ack       (rd_ack),
        .rd_data      (rd_data),
        .period_start (period_start),
        .pwm          (pwm)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int last_count();
        return (top_count == 0) ? 0 : int'(top_count) - 1;
    endfunction

    // Compare the design's outputs with the model at the current negedge.
    task automatic compare_now();
        logic [NCH-1:0] ep;
        logic [NCH-1:0] rising;
        bit eps;
        for (int i = 0; i < NCH; i++) ep[i] = m_run && (m_cnt < int'(m_act[i]));
        chk(pwm == ep, cur_tag, "pwm", pwm, ep);
        eps = m_run && (m_cnt == 0);
        chk(period_start == eps, "R2", "period_start", period_start, eps);
        chk(rd_req == m_busy, "R6", "rd_req", rd_req, m_busy);
        if (m_busy) chk(rd_addr == AW'(int'(base_addr) + m_idx), "R5", "rd_addr",
                        rd_addr, AW'(int'(base_addr) + m_idx));
        rising = pwm & ~prev_pwm;
        if (!period_start) chk(rising == '0, "R7", "mid-period rise", rising, 0);
        prev_pwm = pwm;
    endtask

    // Pick the read response for the coming edge.
    task automatic choose_inputs();
        int r;
        rd_ack  = 1'b0;
        rd_data = $urandom;
        if (m_busy) begin
            case (mode)
                0: begin
                    rd_ack = ($urandom_range(0, 3) != 0);
                    r = $urandom_range(0, 4);
                    if (r == 0) rd_data = '0;
                    else if (r == 1) rd_data = {16'hFFFF, 16'h0000};
                    else if (r == 2) rd_data = {top_count, CW'(last_count())};
                end
                1: rd_ack = 1'b0;
                2: rd_ack = (m_idx < NW - 1) ? 1'b1 : (m_run && m_cnt == last_count());
                default: begin
                    rd_ack  = 1'b1;
                    rd_data = {CW'(2 * m_idx + 2), CW'(2 * m_idx + 1)};
                end
            endcase
        end
    endtask

    // Advance the model by one clock edge from the inputs now driven.
    task automatic model_next();
        bit bnd, take, lastt, ld;
        bnd   = m_run && (m_cnt >= last_count());
        take  = m_busy && rd_ack;
        lastt = take && (m_idx == NW - 1);
        if (take) m_shd[m_idx] = rd_data;
        ld = bnd && (m_valid || lastt);
        if (ld) for (int i = 0; i < NCH; i++) m_act[i] = m_shd[i / 2][(i % 2) * CW +: CW];
        if (!m_busy) begin
            if (!m_valid && m_run) begin
                m_busy = 1'b1;
                m_idx  = 0;
            end
        end else if (take) begin
            if (m_idx == NW - 1) m_busy = 1'b0;
            else m_idx++;
        end
        if (ld) m_valid = 1'b0;
        else if (lastt) m_valid = 1'b1;
        if (!m_run || bnd) m_cnt = 0;
        else m_cnt++;
        m_run = run;
    endtask

    task automatic step();
        compare_now();
        choose_inputs();
        model_next();
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int hc [NCH];
        void'($urandom(32'h5A17));
        for (int w = 0; w < NW; w++) m_shd[w] = '0;
        for (int i = 0; i < NCH; i++) m_act[i] = '0;
        rst_n = 1'b0; run = 1'b0; rd_ack = 1'b0; rd_data = '0;
        top_count = 16; base_addr = 16'h0100;
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk(pwm == '0, "R1", "pwm in reset", pwm, 0);
        chk(rd_req == 1'b0, "R1", "rd_req in reset", rd_req, 0);
        chk(period_start == 1'b0, "R1", "period_start in reset", period_start, 0);
        rst_n = 1'b1;
        step();
        chk(pwm == '0 && !rd_req, "R1", "first cycle after reset", {rd_req, pwm}, 0);

        // Main function with random latency and data (R3).
        run = 1'b1; mode = 0; cur_tag = "R3";
        steps(400);

        // R4: known halves per word; count high cycles over one full period.
        mode = 3; cur_tag = "R4";
        steps(60);
        while (!period_start) step();
        for (int i = 0; i < NCH; i++) hc[i] = 0;
        for (int j = 0; j < 16; j++) begin
            for (int i = 0; i < NCH; i++) hc[i] += pwm[i];
            step();
        end
        for (int i = 0; i < NCH; i++)
            chk(hc[i] == i + 1, "R4", $sformatf("high cycles ch%0d", i), hc[i], i + 1);

        // R8: starve the read port across several boundaries, then recover.
        mode = 1; cur_tag = "R8";
        steps(70);
        mode = 0;
        steps(80);

        // R9: last word accepted in the final cycle of a period.
        mode = 2; cur_tag = "R9";
        steps(120);

        // R10: run low with a fetch in flight.
        mode = 0; cur_tag = "R10";
        run = 1'b0;
        steps(40);

        // R2: one-cycle periods, top 1 and top 0.
        cur_tag = "R2";
        top_count = 1; run = 1'b1;
        steps(100);
        run = 1'b0; steps(10);
        top_count = 0; run = 1'b1;
        steps(60);
        run = 1'b0; steps(10);

        // R5: address wrap near the top of the address space.
        cur_tag = "R5";
        top_count = 7; base_addr = 16'hFFFC; run = 1'b1;
        steps(300);
        run = 1'b0; steps(20);

        // Random phases with varying period lengths and run pauses.
        cur_tag = "R3";
        for (int p = 0; p < 8; p++) begin
            top_count = CW'($urandom_range(2, 40));
            run = 1'b1;
            steps(int'($urandom_range(150, 400)));
            run = 1'b0;
            steps(int'($urandom_range(2, 12)));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule